// File: doc/BRIEF.md
# Host Firmware Window Address Remapper

The block sits between a host firmware-cycle decoder and local memory. It moves one programmable window of the host firmware address space to a chosen place in the local 32-bit address space. Three registers set the window: a control register with two enable bits, a base register and a mask register. A simple register-bus port writes them and reads them back. Every register is split into two 16-bit halves. The upper half describes the local side and the lower half describes the host side. All translation works at 64 KiB granularity.

Host requests arrive on a valid/ready stream. Each request carries a 32-bit address and a read/write flag. Each accepted request produces exactly one response one cycle later. The response carries a hit flag and the translated local address. The response port accepts back-pressure. While `rsp_valid` is high and `rsp_ready` is low, the response stays frozen and `req_ready` is low, so no request is accepted. When the output stage is empty, or is being drained in the same cycle, `req_ready` is high. A request is consumed on any rising edge that has `req_valid` and `req_ready` both high.

For a well-formed window of size S (a power of two, at least 64 KiB) placed at a multiple of S, program the registers as follows. The mask upper half takes the upper 16 bits of the inverse of (S-1). The mask lower half takes S/64 KiB minus one.

Top module: `fwwin_remap`

## Requirements
- R1: After reset the control, base and mask registers all read 0, `rsp_valid` is low and `req_ready` is high.
- R2: The control register is at byte offset 0x0 and stores only bit 8 (translation enable) and bit 10 (firmware-cycle enable). All other bits read 0. The window is active only while both stored bits are 1. While it is inactive, every response has `rsp_hit` low.
- R3: The base register at offset 0x8 and the mask register at offset 0xC store all 32 written bits and read them back. A write to any other offset changes no register. A read at any other offset returns 0.
- R4: A request hits when the window is active and every request address bit [31:16] whose mask bit [15:0] (the keep bit) is 0 equals the matching base bit [15:0].
- R5: On a hit, local address bit 16+i is chosen as follows. It is base bit 16+i when mask bit 16+i (the replace bit) is 1. Otherwise it is request bit 16+i when keep bit i is 1. Otherwise it is 0. Replace wins when both mask bits are set.
- R6: On a hit, local address bits [15:0] equal request address bits [15:0].
- R7: On a miss, or while the window is inactive, the response has `rsp_hit` low and `rsp_addr` equal to 0.
- R8: A request accepted on a rising edge gives `rsp_valid` high after that edge. The response is computed from the register values held before that edge. A register write takes effect for requests accepted on later edges.
- R9: `req_ready` is high exactly when `rsp_valid` is low or `rsp_ready` is high. While `rsp_valid` is high and `rsp_ready` is low, the response fields stay unchanged.
- R10: `rsp_write` equals the `req_write` value of the request that produced the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 8 | Register byte offset for write and read |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read data for the register at `csr_addr` (combinational) |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 32 | Host firmware-cycle address |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Request fell inside the window |
| rsp_addr | output | 32 | Translated local address, 0 on a miss |
| rsp_write | output | 1 | Read/write flag of the request |

## Verification
A response is due one rising edge after its request is accepted. Once due, it holds for as long as `rsp_ready` stays low. `req_ready` and `csr_rdata` follow their inputs within the same cycle. A register write changes translation results starting one edge after the write. The bench keeps a behavioural model that is stepped at each rising edge. The model uses the register values from before the edge, updates its response slot, and only then applies that edge's write. The bench compares every output with the model at the falling edge. By then all registered results of the preceding edge have settled, and no input is changed until after the compare.

// File: rtl/fwwin_pkg.sv
package fwwin_pkg;
  localparam int unsigned FW_ADDR_W   = 32;
  localparam int unsigned FW_CSR_AW   = 8;
  localparam int unsigned OFS_CTRL    = 'h00;
  localparam int unsigned OFS_BASE    = 'h08;
  localparam int unsigned OFS_MASK    = 'h0C;
  localparam int unsigned BIT_XLATE   = 8;
  localparam int unsigned BIT_FWCYC   = 10;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_BASE = 2'd2,
    SEL_MASK = 2'd3
  } csr_sel_e;
endpackage

// File: rtl/fwwin_csr.sv
module fwwin_csr
  import fwwin_pkg::*;
#(
  parameter int unsigned DATA_W    = FW_ADDR_W,
  parameter int unsigned CSR_AW    = FW_CSR_AW,
  parameter int unsigned XLATE_BIT = BIT_XLATE,
  parameter int unsigned FWCYC_BIT = BIT_FWCYC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                csr_wr,
  input  logic [CSR_AW-1:0]   csr_addr,
  input  logic [DATA_W-1:0]   csr_wdata,
  output logic [DATA_W-1:0]   csr_rdata,
  output logic                win_on,
  output logic [DATA_W/2-1:0] base_local,
  output logic [DATA_W/2-1:0] base_host,
  output logic [DATA_W/2-1:0] mask_repl,
  output logic [DATA_W/2-1:0] mask_keep
);
  localparam int unsigned HALF_W = DATA_W / 2;

  function automatic csr_sel_e decode(input logic [CSR_AW-1:0] a);
    if (a == CSR_AW'(OFS_CTRL))      return SEL_CTRL;
    else if (a == CSR_AW'(OFS_BASE)) return SEL_BASE;
    else if (a == CSR_AW'(OFS_MASK)) return SEL_MASK;
    else                             return SEL_NONE;
  endfunction

  csr_sel_e            sel;
  logic                xlate_q;
  logic                fwcyc_q;
  logic [DATA_W-1:0]   base_q;
  logic [DATA_W-1:0]   mask_q;

  assign sel = decode(csr_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xlate_q <= 1'b0;
      fwcyc_q <= 1'b0;
      base_q  <= '0;
      mask_q  <= '0;
    end else if (csr_wr) begin
      unique case (sel)
        SEL_CTRL: begin
          xlate_q <= csr_wdata[XLATE_BIT];
          fwcyc_q <= csr_wdata[FWCYC_BIT];
        end
        SEL_BASE: base_q <= csr_wdata;
        SEL_MASK: mask_q <= csr_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    csr_rdata = '0;
    unique case (sel)
      SEL_CTRL: begin
        csr_rdata[XLATE_BIT] = xlate_q;
        csr_rdata[FWCYC_BIT] = fwcyc_q;
      end
      SEL_BASE: csr_rdata = base_q;
      SEL_MASK: csr_rdata = mask_q;
      default:  csr_rdata = '0;
    endcase
  end

  assign win_on     = xlate_q & fwcyc_q;
  assign base_local = base_q[DATA_W-1:HALF_W];
  assign base_host  = base_q[HALF_W-1:0];
  assign mask_repl  = mask_q[DATA_W-1:HALF_W];
  assign mask_keep  = mask_q[HALF_W-1:0];

  AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && sel == SEL_NONE) |=> ($stable(base_q) && $stable(mask_q) && $stable(win_on))); // R3
endmodule

// File: rtl/fwwin_match.sv
module fwwin_match #(
  parameter int unsigned HALF_W = 16
) (
  input  logic [HALF_W-1:0] req_hi,
  input  logic [HALF_W-1:0] host_hi,
  input  logic [HALF_W-1:0] keep,
  output logic              hit_raw
);
  logic [HALF_W-1:0] differs;

  for (genvar i = 0; i < HALF_W; i++) begin : g_bit
    assign differs[i] = ~keep[i] & (req_hi[i] ^ host_hi[i]);
  end

  assign hit_raw = ~|differs;
endmodule

// File: rtl/fwwin_form.sv
module fwwin_form #(
  parameter int unsigned HALF_W = 16
) (
  input  logic [HALF_W-1:0] req_hi,
  input  logic [HALF_W-1:0] local_base,
  input  logic [HALF_W-1:0] repl,
  input  logic [HALF_W-1:0] keep,
  output logic [HALF_W-1:0] local_hi
);
  for (genvar i = 0; i < HALF_W; i++) begin : g_bit
    always_comb begin
      if (repl[i])      local_hi[i] = local_base[i];
      else if (keep[i]) local_hi[i] = req_hi[i];
      else              local_hi[i] = 1'b0;
    end
  end
endmodule

// File: rtl/fwwin_stage.sv
module fwwin_stage #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_hit,
  input  logic              in_wr,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hit,
  output logic              out_wr,
  output logic [ADDR_W-1:0] out_addr
);
  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_wr    <= 1'b0;
      out_addr  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_hit  <= in_hit;
        out_wr   <= in_wr;
        out_addr <= in_addr;
      end
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hit) && $stable(out_wr) && $stable(out_addr))); // R9
  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R8
endmodule

// File: rtl/fwwin_remap.sv
module fwwin_remap
  import fwwin_pkg::*;
#(
  parameter int unsigned ADDR_W = FW_ADDR_W,
  parameter int unsigned CSR_AW = FW_CSR_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [ADDR_W-1:0] csr_wdata,
  output logic [ADDR_W-1:0] csr_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_write
);
  localparam int unsigned HALF_W = ADDR_W / 2;

  logic              win_on;
  logic [HALF_W-1:0] base_local;
  logic [HALF_W-1:0] base_host;
  logic [HALF_W-1:0] mask_repl;
  logic [HALF_W-1:0] mask_keep;
  logic              hit_raw;
  logic              hit_now;
  logic [HALF_W-1:0] local_hi;
  logic [ADDR_W-1:0] xl_addr;

  fwwin_csr #(
    .DATA_W (ADDR_W),
    .CSR_AW (CSR_AW)
  ) i_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_wr     (csr_wr),
    .csr_addr   (csr_addr),
    .csr_wdata  (csr_wdata),
    .csr_rdata  (csr_rdata),
    .win_on     (win_on),
    .base_local (base_local),
    .base_host  (base_host),
    .mask_repl  (mask_repl),
    .mask_keep  (mask_keep)
  );

  fwwin_match #(.HALF_W(HALF_W)) i_match (
    .req_hi  (req_addr[ADDR_W-1:HALF_W]),
    .host_hi (base_host),
    .keep    (mask_keep),
    .hit_raw (hit_raw)
  );

  fwwin_form #(.HALF_W(HALF_W)) i_form (
    .req_hi     (req_addr[ADDR_W-1:HALF_W]),
    .local_base (base_local),
    .repl       (mask_repl),
    .keep       (mask_keep),
    .local_hi   (local_hi)
  );

  assign hit_now = hit_raw & win_on;
  assign xl_addr = hit_now ? {local_hi, req_addr[HALF_W-1:0]} : '0;

  fwwin_stage #(.ADDR_W(ADDR_W)) i_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_hit    (hit_now),
    .in_wr     (req_write),
    .in_addr   (xl_addr),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_hit   (rsp_hit),
    .out_wr    (rsp_write),
    .out_addr  (rsp_addr)
  );

  AST_MISS_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_addr == '0)); // R7
  AST_HIT_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !win_on) |=> !rsp_hit); // R2
  AST_LOW_HALF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!rsp_hit || rsp_addr[HALF_W-1:0] == $past(req_addr[HALF_W-1:0]))); // R6
endmodule

// File: tb/test_fwwin_remap.sv
`timescale 1ns/1ps
module test_fwwin_remap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0;
  logic [7:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic [31:0] rsp_addr;
  logic        rsp_write;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_ctrl = 0, m_base = 0, m_mask = 0;
  bit          m_valid = 0, m_hit = 0, m_wr = 0;
  logic [31:0] m_addr = 0;
  bit          last_acc = 0;

  always #10 clk = ~clk;

  fwwin_remap i_fwwin_remap (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_addr(rsp_addr), .rsp_write(rsp_write)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] ref_read(input logic [7:0] a);
    case (a)
      8'h00:   return m_ctrl;
      8'h08:   return m_base;
      8'h0C:   return m_mask;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] ref_xlate(input logic [31:0] a, output bit h);
    logic [31:0] r;
    h = (m_ctrl[8] == 1'b1) && (m_ctrl[10] == 1'b1);
    for (int i = 0; i < 16; i++)
      if (!m_mask[i] && (a[16+i] != m_base[i])) h = 0;
    r = 0;
    if (h) begin
      r[15:0] = a[15:0];
      for (int i = 0; i < 16; i++) begin
        if (m_mask[16+i])  r[16+i] = m_base[16+i];
        else if (m_mask[i]) r[16+i] = a[16+i];
        else               r[16+i] = 1'b0;
      end
    end
    return r;
  endfunction

  // model stepped on every rising edge, using pre-edge values
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ctrl = 0; m_base = 0; m_mask = 0; m_valid = 0; last_acc = 0;
    end else begin
      bit rdy;
      bit h;
      rdy = !m_valid || rsp_ready;
      last_acc = req_valid && rdy;
      if (rdy) begin
        m_valid = req_valid;
        if (req_valid) begin
          m_addr = ref_xlate(req_addr, h);
          m_hit = h;
          m_wr = req_write;
        end
      end
      if (csr_wr) begin
        case (csr_addr)
          8'h00: m_ctrl = csr_wdata & 32'h0000_0500;
          8'h08: m_base = csr_wdata;
          8'h0C: m_mask = csr_wdata;
          default: ;
        endcase
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 rsp_valid", {31'b0, rsp_valid}, {31'b0, m_valid});
      chk("R9 req_ready", {31'b0, req_ready}, {31'b0, (!m_valid || rsp_ready)});
      if (m_valid) begin
        chk(m_ctrl == 32'h500 ? "R4 rsp_hit" : "R2 rsp_hit", {31'b0, rsp_hit}, {31'b0, m_hit});
        if (m_hit) begin
          chk("R5 rsp_addr upper", {16'b0, rsp_addr[31:16]}, {16'b0, m_addr[31:16]});
          chk("R6 rsp_addr lower", {16'b0, rsp_addr[15:0]}, {16'b0, m_addr[15:0]});
        end else begin
          chk("R7 rsp_addr miss", rsp_addr, 32'h0);
        end
        chk("R10 rsp_write", {31'b0, rsp_write}, {31'b0, m_wr});
      end
      chk(csr_addr == 8'h00 ? "R2 csr_rdata" : "R3 csr_rdata", csr_rdata, ref_read(csr_addr));
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic csr_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk); #1;
    csr_wr = 1'b0;
  endtask

  task automatic csr_peek(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); #1;
    csr_addr = a;
    #1;
    chk(tag, csr_rdata, exp);
  endtask

  // one request, held until accepted; rsp_ready stays as set
  task automatic send(input logic [31:0] a, input bit w);
    @(negedge clk); #1;
    req_valid = 1'b1; req_addr = a; req_write = w;
    do begin
      @(negedge clk); #1;
    end while (!last_acc);
    req_valid = 1'b0;
  endtask

  task automatic stream(input int n, input int ready_pct, input bit aim);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      rsp_ready = ($urandom % 100) < ready_pct;
      if (!req_valid || last_acc) begin
        req_valid = ($urandom % 100) < 75;
        req_write = $urandom % 2;
        if (aim && ($urandom % 3 != 0))
          req_addr = {(m_base[15:0] & ~m_mask[15:0]) | (16'($urandom) & m_mask[15:0]), 16'($urandom)};
        else
          req_addr = $urandom;
      end
    end
    @(negedge clk); #1;
    req_valid = 1'b0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
    chk("R1 req_ready after reset", {31'b0, req_ready}, 32'h1);
    csr_peek("R1 ctrl reset", 8'h00, 32'h0);
    csr_peek("R1 base reset", 8'h08, 32'h0);
    csr_peek("R1 mask reset", 8'h0C, 32'h0);

    // window disabled: everything misses
    csr_write(8'h08, 32'h8A00_0FF0);
    csr_write(8'h0C, 32'hFFF0_000F);
    send(32'h0FF3_1234, 1'b0);
    @(negedge clk);
    chk("R7 disabled hit", {31'b0, rsp_hit}, 32'h0);
    chk("R7 disabled addr", rsp_addr, 32'h0);

    // only one enable bit
    csr_write(8'h00, 32'h0000_0100);
    send(32'h0FF3_1234, 1'b1);
    @(negedge clk);
    chk("R2 one enable bit no hit", {31'b0, rsp_hit}, 32'h0);
    csr_write(8'h00, 32'hFFFF_FFFF);
    csr_peek("R2 ctrl keeps bits 8 and 10", 8'h00, 32'h0000_0500);

    // well-formed 1 MiB window
    send(32'h0FF3_1234, 1'b1);
    @(negedge clk);
    chk("R4 in-window hit", {31'b0, rsp_hit}, 32'h1);
    chk("R5 in-window addr", rsp_addr, 32'h8A03_1234);
    chk("R10 write flag", {31'b0, rsp_write}, 32'h1);
    send(32'h0FE3_1234, 1'b0);
    @(negedge clk);
    chk("R7 outside window", rsp_addr, 32'h0);

    // unmapped offsets are ignored
    csr_write(8'h04, 32'hDEAD_BEEF);
    csr_write(8'h10, 32'h1234_5678);
    csr_peek("R3 unmapped read", 8'h04, 32'h0);
    csr_peek("R3 base unchanged", 8'h08, 32'h8A00_0FF0);
    csr_peek("R3 mask unchanged", 8'h0C, 32'hFFF0_000F);
    csr_peek("R3 ctrl unchanged", 8'h00, 32'h0000_0500);

    stream(400, 70, 1'b1);

    // irregular mask: replace+keep overlap, neither bits
    csr_write(8'h08, 32'h5A5A_A5A5);
    csr_write(8'h0C, 32'h00FF_0F0F);
    send(32'hA3A0_00FF, 1'b0);
    @(negedge clk);
    chk("R4 irregular hit", {31'b0, rsp_hit}, 32'h1);
    chk("R5 replace wins and neither gives 0", rsp_addr, 32'h035A_00FF);
    stream(400, 50, 1'b1);

    // write and request in the same cycle: old values apply (R8)
    csr_write(8'h08, 32'h1100_0020);
    csr_write(8'h0C, 32'hFFFF_0000);
    @(negedge clk); #1;
    req_valid = 1'b1; req_addr = 32'h0020_0042; req_write = 1'b0;
    csr_wr = 1'b1; csr_addr = 8'h08; csr_wdata = 32'h2200_0030;
    @(negedge clk); #1;
    csr_wr = 1'b0;
    req_addr = 32'h0020_0043;
    chk("R8 same-cycle write uses old base", rsp_addr, 32'h1100_0042);
    @(negedge clk); #1;
    req_valid = 1'b0;
    chk("R8 later request sees new base", {31'b0, rsp_hit}, 32'h0);

    // back-pressure heavy stream
    stream(600, 25, 1'b0);
    csr_write(8'h0C, 32'hFFF8_0007);
    stream(400, 40, 1'b1);

    done = 1;
    summary();
    $finish;
  end
endmodule